// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

This block watches one channel's system transmit clock from the master clock domain. The transmit clock is brought through a two-flop synchroniser. Each transition seen after that restarts an idle counter. When the counter passes a fixed limit of master-clock cycles, the block raises a loss flag. The flag stays up until the transmit clock moves again. While the flag is up, the block asks for an interrupt unless it is masked. It also pulls the line driver's output enable low, so the line goes to high impedance.

The output enable is not pulled low in two cases. One is when the channel is in remote loopback. The other is when the channel sends an internal pattern timed by the master clock; the forced all-ones and alarm-indication conditions count here. The block also chooses the reference clock for pattern generation. A software select bit picks between the transmit clock and the master clock. Either forced condition overrides that bit and selects the master clock. A strobe marks the chosen active edge of the transmit clock.

Top module: `txclk_loss_monitor`

## Requirements
- R1: After reset, `los_flag` and `irq` are 0 and `drv_oe` is 1.
- R2: `los_flag` rises once `LOSS_LIMIT`+1 (default 71) consecutive master-clock cycles have passed with no synchronised transmit-clock transition. It is never set earlier than that.
- R3: While the transmit clock keeps toggling with a half period well under `LOSS_LIMIT` master cycles, `los_flag` stays 0.
- R4: `los_flag` returns to 0 on the cycle after the first synchronised transition that follows a loss.
- R5: `irq` equals `los_flag` AND NOT `irq_mask`.
- R6: `drv_oe` is 0 only when `los_flag` is 1, `rlb_en` is 0 and the channel is not sending a master-clock pattern. In every other case it is 1.
- R7: A master-clock pattern is present when `auto_ones` or `ais_cond` is 1. It is also present when `pat_mode` is active and `pat_clk_sel` is 1. The active codes are 1 all ones, 2 all zeros, 3 PRBS, 4 QRSS and 5 in-band loop code; codes 0, 6 and 7 mean no pattern.
- R8: With `auto_ones` and `ais_cond` both 0, `ref_is_mclk` follows `pat_clk_sel`, where 1 selects the master clock and 0 the transmit clock.
- R9: When `auto_ones` or `ais_cond` is 1, `ref_is_mclk` is 1 whatever `pat_clk_sel` holds.
- R10: `edge_stb` pulses for one master cycle per synchronised transmit-clock edge of the kind `edge_sel` selects (0 rising, 1 falling). It is silent for the other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_mst_n | input | 1 | Asynchronous active-low reset |
| txclk_in | input | 1 | System transmit clock, asynchronous |
| edge_sel | input | 1 | Active edge select, 0 rising, 1 falling |
| irq_mask | input | 1 | Interrupt mask, 1 masks |
| rlb_en | input | 1 | Remote loopback active |
| pat_mode | input | 3 | Internal pattern code |
| pat_clk_sel | input | 1 | Pattern reference select, 1 master clock |
| auto_ones | input | 1 | Automatic all-ones condition |
| ais_cond | input | 1 | Alarm indication condition |
| edge_stb | output | 1 | Active-edge strobe |
| los_flag | output | 1 | Transmit clock loss status |
| irq | output | 1 | Interrupt request level |
| drv_oe | output | 1 | Line driver output enable |
| ref_is_mclk | output | 1 | Pattern reference is master clock |

## Verification
Assertions check several rules on every cycle. The idle counter never passes its limit. The loss flag rises only after the counter has reached that limit. The flag drops right after a detected transition. The interrupt is never high under the mask. The output enable stays high while no loss is flagged. The forced conditions always select the master clock. The bench scenarios cover the rest: the cycle window in which loss appears after the clock stops, recovery when the clock restarts, the mix of loopback, pattern and forced conditions that decides the output enable, and which edge drives the strobe.

// File: rtl/txclk_loss_pkg.sv
package txclk_loss_pkg;
  typedef enum logic [2:0] {
    PAT_NONE  = 3'd0,
    PAT_ONES  = 3'd1,
    PAT_ZEROS = 3'd2,
    PAT_PRBS  = 3'd3,
    PAT_QRSS  = 3'd4,
    PAT_ILC   = 3'd5
  } pat_mode_e;

  function automatic logic pat_active(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction
endpackage

// File: rtl/txclk_sync_edge.sv
module txclk_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txclk_async,
  input  logic edge_sel,
  output logic toggle,
  output logic edge_stb
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], txclk_async};
      hist_q <= synced;
    end
  end

  assign toggle   = synced ^ hist_q;
  assign edge_stb = edge_sel ? (hist_q & ~synced) : (synced & ~hist_q);

  p_stb_needs_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |-> toggle);
endmodule

// File: rtl/txclk_idle_timer.sv
module txclk_idle_timer #(
  parameter int LOSS_LIMIT = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic los
);
  localparam int CW = $clog2(LOSS_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LOSS_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          los_q, los_d;

  always_comb begin
    cnt_d = cnt_q;
    los_d = los_q;
    if (toggle) begin
      cnt_d = '0;
      los_d = 1'b0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      los_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      los_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      los_q <= los_d;
    end
  end

  assign los = los_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  p_rise_after_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> ($past(cnt_q) == LIM));
  p_clear_on_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle |=> !los_q);
endmodule

// File: rtl/txclk_ref_select.sv
module txclk_ref_select
  import txclk_loss_pkg::*;
(
  input  logic       los,
  input  logic       irq_mask,
  input  logic       rlb_en,
  input  logic [2:0] pat_mode,
  input  logic       pat_clk_sel,
  input  logic       auto_ones,
  input  logic       ais_cond,
  output logic       ref_is_mclk,
  output logic       irq,
  output logic       drv_oe
);
  logic forced;
  logic mclk_pattern;

  always_comb begin
    forced       = auto_ones | ais_cond;
    ref_is_mclk  = forced | pat_clk_sel;
    mclk_pattern = forced | (pat_active(pat_mode) & pat_clk_sel);
    irq          = los & ~irq_mask;
    drv_oe       = ~(los & ~rlb_en & ~mclk_pattern);
  end
endmodule

// File: rtl/txclk_loss_monitor.sv
module txclk_loss_monitor #(
  parameter int LOSS_LIMIT  = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_mst,
  input  logic       rst_mst_n,
  input  logic       txclk_in,
  input  logic       edge_sel,
  input  logic       irq_mask,
  input  logic       rlb_en,
  input  logic [2:0] pat_mode,
  input  logic       pat_clk_sel,
  input  logic       auto_ones,
  input  logic       ais_cond,
  output logic       edge_stb,
  output logic       los_flag,
  output logic       irq,
  output logic       drv_oe,
  output logic       ref_is_mclk
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  logic       toggle;

  always_ff @(posedge clk_mst or negedge rst_mst_n) begin
    if (!rst_mst_n) rst_pipe_q <= 2'b00;
    else            rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  txclk_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_mst), .rst_n(rst_n), .txclk_async(txclk_in),
    .edge_sel(edge_sel), .toggle(toggle), .edge_stb(edge_stb));

  txclk_idle_timer #(.LOSS_LIMIT(LOSS_LIMIT)) u_timer (
    .clk(clk_mst), .rst_n(rst_n), .toggle(toggle), .los(los_flag));

  txclk_ref_select u_sel (
    .los(los_flag), .irq_mask(irq_mask), .rlb_en(rlb_en),
    .pat_mode(pat_mode), .pat_clk_sel(pat_clk_sel), .auto_ones(auto_ones),
    .ais_cond(ais_cond), .ref_is_mclk(ref_is_mclk), .irq(irq),
    .drv_oe(drv_oe));

  p_mask_blocks_irq_r5: assert property (@(posedge clk_mst) disable iff (!rst_n)
    irq_mask |-> !irq);
  p_oe_without_loss_r6: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !los_flag |-> drv_oe);
  p_loopback_keeps_oe_r7: assert property (@(posedge clk_mst) disable iff (!rst_n)
    rlb_en |-> drv_oe);
  p_forced_ref_r9: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (auto_ones || ais_cond) |-> ref_is_mclk);
endmodule

// File: tb/txclk_loss_monitor_test.sv
module txclk_loss_monitor_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk_mst = 1'b0, rst_mst_n = 1'b0, txclk_in = 1'b0;
  logic edge_sel = 1'b0, irq_mask = 1'b0, rlb_en = 1'b0;
  logic [2:0] pat_mode = 3'd0;
  logic pat_clk_sel = 1'b0, auto_ones = 1'b0, ais_cond = 1'b0;
  logic edge_stb, los_flag, irq, drv_oe, ref_is_mclk;
  logic tx_run = 1'b0;
  int   tx_half = 20;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  txclk_loss_monitor uut (.*);

  always #(CLK_PERIOD/2) clk_mst = ~clk_mst;

  initial forever begin
    if (tx_run) #(tx_half * 1ns) txclk_in = ~txclk_in;
    else #1ns;
  end

  function automatic bit exp_ref(bit ps, bit ao, bit ai);
    return ao | ai | ps;
  endfunction
  function automatic bit exp_oe(bit los, bit rl, logic [2:0] pm, bit ps, bit ao, bit ai);
    bit mp;
    mp = ao | ai | ((pm >= 3'd1 && pm <= 3'd5) & ps);
    return !(los & !rl & !mp);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk_mst);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cyc(3);
    rst_mst_n = 1'b1;
    cyc(4);
    chk("R1 los", los_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 oe", drv_oe, 1'b1);

    for (int it = 0; it < 6; it++) begin
      tx_half = 15 + ($urandom % 36);
      tx_run = 1'b1;
      cyc(200);
      chk("R3 running", los_flag, 1'b0);
      chk("R6 oe running", drv_oe, 1'b1);

      tx_run = 1'b0;
      cyc(55);
      chk("R2 early", los_flag, 1'b0);
      cyc(30);
      chk("R2 lost", los_flag, 1'b1);

      for (int k = 0; k < 10; k++) begin
        irq_mask = 1'($urandom); rlb_en = 1'($urandom);
        pat_mode = 3'($urandom); pat_clk_sel = 1'($urandom);
        auto_ones = ($urandom % 4) == 0; ais_cond = ($urandom % 4) == 0;
        cyc(1);
        chk("R5 irq", irq, !irq_mask);
        chk("R6 R7 oe", drv_oe,
            exp_oe(1'b1, rlb_en, pat_mode, pat_clk_sel, auto_ones, ais_cond));
        chk(auto_ones | ais_cond ? "R9 ref" : "R8 ref", ref_is_mclk,
            exp_ref(pat_clk_sel, auto_ones, ais_cond));
      end
      irq_mask = 0; rlb_en = 0; pat_mode = 0; pat_clk_sel = 0;
      auto_ones = 0; ais_cond = 0;
      cyc(1);
      chk("R6 hiz", drv_oe, 1'b0);

      tx_run = 1'b1;
      cyc(12);
      chk("R4 recover", los_flag, 1'b0);
      chk("R5 irq clear", irq, 1'b0);
    end

    // directed: no pattern (codes 0,6,7) with master select still goes hi-z
    tx_run = 1'b0;
    cyc(90);
    for (int c = 0; c < 8; c++) begin
      pat_mode = 3'(c); pat_clk_sel = 1'b1;
      cyc(1);
      chk("R7 code", drv_oe, (c >= 1 && c <= 5));
    end
    pat_mode = 0; pat_clk_sel = 0;

    // edge select
    for (int s = 0; s < 2; s++) begin
      int cnt;
      edge_sel = 1'(s);
      txclk_in = 1'b0; cyc(6);
      cnt = 0; txclk_in = 1'b1;
      for (int j = 0; j < 6; j++) begin cyc(1); cnt += edge_stb; end
      chk("R10 rise", cnt == 1, s == 0);
      cnt = 0; txclk_in = 1'b0;
      for (int j = 0; j < 6; j++) begin cyc(1); cnt += edge_stb; end
      chk("R10 fall", cnt == 1, s == 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule